// File: doc/BRIEF.md
# Serial-to-Parallel Coprocessor Bridge

This block sits between a bit-serial 32-bit processor datapath and a parallel arithmetic coprocessor that speaks a ready/valid handshake. When the decode stage presents a register-register instruction that belongs to the coprocessor, the bridge takes it over. It collects both source operands one bit per cycle into two parallel registers. It then raises a request towards the coprocessor once the coprocessor reports that it can take one, and holds the core stalled until the answer arrives. Finally it plays the answer back one bit per cycle, together with a register-file write enable, so the core writes it back the way it would write back a load.

The sequence is run by a state machine with five states. `IDLE` waits for a coprocessor instruction. The `accept` transition leaves `IDLE` for `SHIFT_IN`, which lasts 32 cycles. The `collected` transition goes to `WAIT_RDY`. The `issue` transition, taken when the coprocessor is ready, goes to `WAIT_VALID`. The `capture` transition, taken when the response is valid, goes to `SHIFT_OUT`, which lasts 32 cycles. The `retire` transition returns to `IDLE`. A 5-bit counter times both shift phases. Operands enter least-significant bit first and the result leaves least-significant bit first.

Top module: `serial_copro_bridge`

## Requirements
- R1: An instruction is taken only in `IDLE` with `insn_valid` high, `insn_word[6:0]` equal to 7'b0110011 and `insn_word[25]` equal to 1. Any other opcode, or bit 25 equal to 0, leaves `cp_valid`, `core_stall` and `rf_wen` low.
- R2: Both operands are sampled on the 32 clock edges that follow the accepting edge, one bit each per edge, least-significant bit first. The k-th sampled bit of `opa_bit` and `opb_bit` becomes bit k of `cp_opa` and `cp_opb`.
- R3: `cp_op` carries `insn_word[14:12]` of the accepted instruction for the whole of the request.
- R4: After the response, `rf_wen` is high for exactly 32 consecutive cycles. In the k-th of them, `res_bit` equals bit k of the captured result.
- R5: `cp_valid` rises only on an edge at which `cp_ready` is sampled high after operand collection. While `cp_ready` stays low, `cp_valid` stays low.
- R6: `core_stall` is low during operand collection and result playback. It is high from the end of collection until the response is captured.
- R7: Once raised, `cp_valid` stays high with `cp_opa`, `cp_opb` and `cp_op` stable until `cp_done` is sampled high. On that edge the result is captured and `cp_valid` falls.
- R8: `insn_valid` is ignored outside `IDLE`. A coprocessor instruction presented while a transfer is in progress starts no further transfer.
- R9: After reset, `core_stall`, `rf_wen` and `cp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| insn_valid | input | 1 | Decode stage presents an instruction |
| insn_word | input | 32 | Instruction word |
| opa_bit | input | 1 | Serial first operand, LSB first |
| opb_bit | input | 1 | Serial second operand, LSB first |
| core_stall | output | 1 | Hold the core while waiting on the coprocessor |
| rf_wen | output | 1 | Register-file write enable during result playback |
| res_bit | output | 1 | Serial result, LSB first |
| cp_valid | output | 1 | Request to the coprocessor |
| cp_ready | input | 1 | Coprocessor can accept a request |
| cp_op | output | 3 | Operation select (funct3) |
| cp_opa | output | XLEN | Parallel first operand |
| cp_opb | output | XLEN | Parallel second operand |
| cp_done | input | 1 | Coprocessor response valid |
| cp_result | input | XLEN | Coprocessor result |

## Verification
A wrong state or a wrong counter value shows up within one transfer. If the counter is off by one, the operands reaching the coprocessor are shifted by one bit, and the write-back window is 31 or 33 cycles long. If the machine leaves a wait state early, `cp_valid` is raised without ready or dropped before `cp_done`, and `core_stall` stops matching the wait window on the same cycle. If the machine leaves `IDLE` when it should not, a spurious `rf_wen` burst appears within about 70 cycles of an instruction that should have been ignored.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
    localparam int ILEN = 32;
    localparam logic [6:0] OPC_REG_REG = 7'b0110011;
    localparam int SEL_BIT = 25;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHIFT_IN,
        ST_WAIT_RDY,
        ST_WAIT_VALID,
        ST_SHIFT_OUT
    } br_state_e;
endpackage

// File: rtl/bridge_decode.sv
module bridge_decode
    import bridge_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            insn_valid,
    input  logic [ILEN-1:0] insn_word,
    input  logic            capture,
    output logic            hit,
    output logic [2:0]      op_q
);
    assign hit = insn_valid
              && (insn_word[6:0] == OPC_REG_REG)
              && insn_word[SEL_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q <= '0;
        end else if (capture) begin
            op_q <= insn_word[14:12];
        end
    end
endmodule

// File: rtl/bridge_sipo.sv
module bridge_sipo #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            shift_en,
    input  logic            ser_in,
    output logic [XLEN-1:0] par_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            par_q <= '0;
        end else if (shift_en) begin
            par_q <= {ser_in, par_q[XLEN-1:1]};
        end
    end
endmodule

// File: rtl/bridge_piso.sv
module bridge_piso #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [XLEN-1:0] par_in,
    input  logic            shift_en,
    output logic            ser_out
);
    logic [XLEN-1:0] hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (load) begin
            hold_q <= par_in;
        end else if (shift_en) begin
            hold_q <= {1'b0, hold_q[XLEN-1:1]};
        end
    end

    assign ser_out = hold_q[0];
endmodule

// File: rtl/bridge_fsm.sv
module bridge_fsm
    import bridge_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic cp_ready,
    input  logic cp_done,
    output logic accept,
    output logic shift_in,
    output logic shift_out,
    output logic load_res,
    output logic stall,
    output logic req_valid,
    output logic wen
);
    localparam int CNT_W = $clog2(XLEN);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(XLEN - 1);

    br_state_e  state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic       cnt_last;

    assign cnt_last = (cnt_q == CNT_LAST);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (hit)      state_d = ST_SHIFT_IN;
            ST_SHIFT_IN:   if (cnt_last) state_d = ST_WAIT_RDY;
            ST_WAIT_RDY:   if (cp_ready) state_d = ST_WAIT_VALID;
            ST_WAIT_VALID: if (cp_done)  state_d = ST_SHIFT_OUT;
            ST_SHIFT_OUT:  if (cnt_last) state_d = ST_IDLE;
            default:                     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_SHIFT_IN || state_q == ST_SHIFT_OUT) begin
                cnt_q <= cnt_q + 1'b1;
            end else begin
                cnt_q <= '0;
            end
        end
    end

    always_comb begin
        accept    = 1'b0;
        shift_in  = 1'b0;
        shift_out = 1'b0;
        load_res  = 1'b0;
        stall     = 1'b0;
        req_valid = 1'b0;
        wen       = 1'b0;
        unique case (state_q)
            ST_IDLE:       accept = hit;
            ST_SHIFT_IN:   shift_in = 1'b1;
            ST_WAIT_RDY:   stall = 1'b1;
            ST_WAIT_VALID: begin
                stall     = 1'b1;
                req_valid = 1'b1;
                load_res  = cp_done;
            end
            ST_SHIFT_OUT: begin
                shift_out = 1'b1;
                wen       = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/serial_copro_bridge.sv
module serial_copro_bridge
    import bridge_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            insn_valid,
    input  logic [ILEN-1:0] insn_word,
    input  logic            opa_bit,
    input  logic            opb_bit,
    output logic            core_stall,
    output logic            rf_wen,
    output logic            res_bit,
    output logic            cp_valid,
    input  logic            cp_ready,
    output logic [2:0]      cp_op,
    output logic [XLEN-1:0] cp_opa,
    output logic [XLEN-1:0] cp_opb,
    input  logic            cp_done,
    input  logic [XLEN-1:0] cp_result
);
    localparam int NOPS = 2;

    logic hit, accept, shift_in, shift_out, load_res;
    logic [NOPS-1:0]      ser_bits;
    logic [XLEN-1:0]      opnd_q [NOPS];

    assign ser_bits = {opb_bit, opa_bit};

    bridge_decode u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .insn_valid (insn_valid),
        .insn_word  (insn_word),
        .capture    (accept),
        .hit        (hit),
        .op_q       (cp_op)
    );

    bridge_fsm #(.XLEN(XLEN)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit       (hit),
        .cp_ready  (cp_ready),
        .cp_done   (cp_done),
        .accept    (accept),
        .shift_in  (shift_in),
        .shift_out (shift_out),
        .load_res  (load_res),
        .stall     (core_stall),
        .req_valid (cp_valid),
        .wen       (rf_wen)
    );

    for (genvar g = 0; g < NOPS; g++) begin : g_opnd
        bridge_sipo #(.XLEN(XLEN)) u_sipo (
            .clk      (clk),
            .rst_n    (rst_n),
            .shift_en (shift_in),
            .ser_in   (ser_bits[g]),
            .par_q    (opnd_q[g])
        );
    end

    assign cp_opa = opnd_q[0];
    assign cp_opb = opnd_q[1];

    bridge_piso #(.XLEN(XLEN)) u_piso (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_res),
        .par_in   (cp_result),
        .shift_en (shift_out),
        .ser_out  (res_bit)
    );
endmodule

// File: rtl/bridge_checker.sv
module bridge_checker #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            core_stall,
    input logic            rf_wen,
    input logic            cp_valid,
    input logic            cp_ready,
    input logic            cp_done,
    input logic [2:0]      cp_op,
    input logic [XLEN-1:0] cp_opa,
    input logic [XLEN-1:0] cp_opb
);
    localparam int RUN_W = $clog2(XLEN) + 2;
    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      run_q <= '0;
        else if (rf_wen) run_q <= run_q + 1'b1;
        else             run_q <= '0;
    end

    // R4: write-back window never exceeds XLEN cycles
    p_wen_max_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wen |-> (run_q < RUN_W'(XLEN)));

    // R4: write-back window is exactly XLEN cycles long
    p_wen_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rf_wen) |-> (run_q == RUN_W'(XLEN)));

    // R5: request rises only after ready was seen
    p_req_after_rdy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cp_valid) |-> $past(cp_ready));

    // R6: stall and write-back never overlap
    p_stall_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        core_stall |-> !rf_wen);

    // R6: request implies stalled core
    p_req_stalls_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cp_valid |-> core_stall);

    // R7: request held until response
    p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_valid && !cp_done) |=> cp_valid);

    // R7: request drops after response
    p_req_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_valid && cp_done) |=> !cp_valid);

    // R7: payload stable while request is held
    p_payload_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_valid && $past(cp_valid)) |->
            ($stable(cp_opa) && $stable(cp_opb) && $stable(cp_op)));
endmodule

bind serial_copro_bridge bridge_checker #(.XLEN(XLEN)) u_bridge_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .core_stall (core_stall),
    .rf_wen     (rf_wen),
    .cp_valid   (cp_valid),
    .cp_ready   (cp_ready),
    .cp_done    (cp_done),
    .cp_op      (cp_op),
    .cp_opa     (cp_opa),
    .cp_opb     (cp_opb)
);

// File: tb/test_serial_copro_bridge.sv
module test_serial_copro_bridge;
    localparam int XLEN = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            insn_valid = 1'b0;
    logic [31:0]     insn_word = '0;
    logic            opa_bit = 1'b0, opb_bit = 1'b0;
    logic            core_stall, rf_wen, res_bit, cp_valid;
    logic            cp_ready = 1'b0;
    logic [2:0]      cp_op;
    logic [XLEN-1:0] cp_opa, cp_opb;
    logic            cp_done = 1'b0;
    logic [XLEN-1:0] cp_result = '0;

    int checks = 0;
    int errors = 0;
    int res_seen = 0;
    bit finished = 1'b0;

    logic [31:0] q_a[$], q_b[$], q_rsp[$], q_res[$];
    logic [2:0]  q_op[$];
    int          q_gap[$];

    always #4 clk = ~clk;

    serial_copro_bridge #(.XLEN(XLEN)) i_serial_copro_bridge (
        .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn_word(insn_word),
        .opa_bit(opa_bit), .opb_bit(opb_bit), .core_stall(core_stall),
        .rf_wen(rf_wen), .res_bit(res_bit), .cp_valid(cp_valid),
        .cp_ready(cp_ready), .cp_op(cp_op), .cp_opa(cp_opa), .cp_opb(cp_opb),
        .cp_done(cp_done), .cp_result(cp_result)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_insn(input logic [6:0] opc,
                                            input logic b25, input logic [2:0] f3);
        return {6'b000000, b25, 5'd3, 5'd2, f3, 5'd1, opc};
    endfunction

    // coprocessor model: checks requests (R2, R3, R6) and answers
    initial begin
        bit busy = 1'b0;
        int wait_n = 0;
        logic [31:0] rsp = '0;
        forever begin
            @(negedge clk);
            if (cp_done) begin
                cp_done = 1'b0;
            end else if (cp_valid && !busy) begin
                if (q_a.size() == 0) begin
                    chk(1'b0, "R1 unexpected request", 32'd1, 32'd0);
                end else begin
                    logic [31:0] ea, eb;
                    logic [2:0]  eo;
                    ea = q_a.pop_front(); eb = q_b.pop_front();
                    eo = q_op.pop_front(); wait_n = q_gap.pop_front();
                    rsp = q_rsp.pop_front();
                    chk(cp_opa == ea, "R2 operand a", cp_opa, ea);
                    chk(cp_opb == eb, "R2 operand b", cp_opb, eb);
                    chk(cp_op == eo, "R3 op select", {29'b0, cp_op}, {29'b0, eo});
                    chk(core_stall == 1'b1, "R6 stall during request", {31'b0, core_stall}, 32'd1);
                    busy = 1'b1;
                end
            end
            if (busy) begin
                if (wait_n == 0) begin
                    chk(cp_valid == 1'b1, "R7 valid held", {31'b0, cp_valid}, 32'd1);
                    cp_result = rsp;
                    cp_done = 1'b1;
                    busy = 1'b0;
                end else begin
                    wait_n--;
                end
            end
        end
    end

    // result monitor (R4)
    initial begin
        logic [31:0] acc = '0;
        int nb = 0;
        forever begin
            @(negedge clk);
            if (rf_wen) begin
                acc[nb] = res_bit;
                nb++;
                if (nb == 32) begin
                    if (q_res.size() == 0) begin
                        chk(1'b0, "R4 unexpected write-back", acc, 32'd0);
                    end else begin
                        logic [31:0] er;
                        er = q_res.pop_front();
                        chk(acc == er, "R4 serial result", acc, er);
                    end
                    nb = 0;
                    res_seen++;
                end
            end
        end
    end

    task automatic send_op(input logic [31:0] a, input logic [31:0] b,
                           input logic [2:0] f3, input int rdy_gap,
                           input int done_gap, input bit poke);
        int prev;
        logic [31:0] r;
        r = (a * b) ^ {29'b0, f3};
        q_a.push_back(a); q_b.push_back(b); q_op.push_back(f3);
        q_gap.push_back(done_gap); q_rsp.push_back(r); q_res.push_back(r);
        prev = res_seen;
        @(negedge clk);
        insn_valid = 1'b1;
        insn_word = mk_insn(7'b0110011, 1'b1, f3);
        cp_ready = (rdy_gap == 0);
        for (int k = 0; k < 32; k++) begin
            @(negedge clk);
            if (k == 0) insn_valid = 1'b0;
            if (poke && k == 5) begin
                insn_valid = 1'b1;
                insn_word = mk_insn(7'b0110011, 1'b1, ~f3);
            end
            if (poke && k == 6) insn_valid = 1'b0;
            opa_bit = a[k];
            opb_bit = b[k];
            if (k == 16)
                chk(core_stall == 1'b0, "R6 no stall while collecting", {31'b0, core_stall}, 32'd0);
        end
        @(negedge clk);
        chk(core_stall == 1'b1, "R6 stall after collection", {31'b0, core_stall}, 32'd1);
        if (rdy_gap > 0) begin
            bit quiet = 1'b1;
            for (int k = 0; k < rdy_gap; k++) begin
                if (cp_valid) quiet = 1'b0;
                @(negedge clk);
            end
            chk(quiet, "R5 no request without ready", {31'b0, ~quiet}, 32'd0);
            cp_ready = 1'b1;
        end
        while (res_seen == prev) @(negedge clk);
        @(negedge clk);
        chk(rf_wen == 1'b0 && core_stall == 1'b0, "R4 window closed",
            {30'b0, rf_wen, core_stall}, 32'd0);
        cp_ready = 1'b0;
    endtask

    task automatic quiet_window(input string tag, input int n);
        bit quiet = 1'b1;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (cp_valid || core_stall || rf_wen) quiet = 1'b0;
        end
        chk(quiet, tag, {31'b0, ~quiet}, 32'd0);
    endtask

    task automatic send_miss(input logic [31:0] w, input string tag);
        @(negedge clk);
        insn_valid = 1'b1;
        insn_word = w;
        cp_ready = 1'b1;
        @(negedge clk);
        insn_valid = 1'b0;
        quiet_window(tag, 80);
        cp_ready = 1'b0;
    endtask

    initial begin
        repeat (2000000 / 8 / 10) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=0", 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!core_stall && !rf_wen && !cp_valid, "R9 reset state",
            {29'b0, core_stall, rf_wen, cp_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!core_stall && !rf_wen && !cp_valid, "R9 after release",
            {29'b0, core_stall, rf_wen, cp_valid}, 32'd0);

        send_op(32'h1234_5678, 32'h0000_0003, 3'd0, 0, 0, 1'b0);
        send_op(32'hFFFF_FFFF, 32'h8000_0001, 3'd3, 4, 2, 1'b0);
        send_op(32'h8000_0000, 32'h0000_0001, 3'd4, 0, 7, 1'b0);
        send_op(32'hA5A5_5A5A, 32'h0F0F_F0F0, 3'd7, 1, 0, 1'b0);
        send_op(32'h0000_0000, 32'hDEAD_BEEF, 3'd5, 2, 3, 1'b0);

        send_miss(mk_insn(7'b0110011, 1'b0, 3'd0), "R1 bit25 clear ignored");
        send_miss(mk_insn(7'b0010011, 1'b1, 3'd0), "R1 other opcode ignored");

        // R8: instruction presented during collection is ignored
        send_op(32'h0BAD_F00D, 32'h1357_9BDF, 3'd2, 0, 1, 1'b1);
        quiet_window("R8 busy instruction ignored", 80);

        send_op(32'h7FFF_FFFF, 32'h7FFF_FFFF, 3'd6, 3, 0, 1'b0);
        chk(q_res.size() == 0 && q_a.size() == 0, "R4 scoreboard drained",
            q_res.size(), 32'd0);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule